// File: doc/BRIEF.md
# Block Cipher Register Sequencer

This block is the register-facing control layer of a block-cipher accelerator. Software reaches it through a small word-wide register bus that has separate read and write strobes. Through that bus it loads up to eight key words and sets the operating controls. It pushes a 128-bit plaintext or ciphertext block in as four 32-bit words and pulls the 128-bit result out as four words. The cipher rounds live in a separate core. This block hands that core a data block, a 256-bit key image and a mode code with a one-cycle start pulse, and it takes back a 128-bit result on a one-cycle done pulse.

The sequencer steps through its input, compute and output phases. It keeps sticky completion, read-error and write-error flags and drives a single interrupt line. It also has a key-derivation mode that needs no data input. In that mode a computation starts as soon as the block is enabled, and the result is written back over the key words. The block then switches itself off. A bus access made at the wrong point in the sequence raises an error flag but does not disturb the block being processed.

Top module: `cipher_seq_top`

## Requirements
- R1: After reset the control register, the status register, `irq` and `core_start` are all 0. Address map: 0 control, 1 status, 2 data-in, 3 data-out, 8 to 15 key words 0 to 7. Control bits: [0] enable, [2:1] mode, [3] 256-bit key, [4] completion-interrupt enable, [5] error-interrupt enable, [6] DMA output, [7] clear completion, [8] clear read error, [9] clear write error. Status bits: [0] completion, [1] read error, [2] write error, [3] computing.
- R2: Key word 0 is the least significant 32 bits of `core_key`. When the 256-bit key bit is 0, `core_key[255:128]` is driven as zero. When it is 1, words 4 to 7 fill the upper half.
- R3: A key-word write made while enable is 1 is discarded.
- R4: In modes 0, 2 and 3 (encrypt, decrypt, derive-then-decrypt), four data-in writes fill the block, and the first word lands in bits [127:96]. After the fourth write, `core_start` pulses for one cycle and `core_mode` carries the mode code. Idle cycles between writes are allowed.
- R5: After `core_done`, four data-out reads return the result, with bits [127:96] first. The sequencer then returns to the input phase.
- R6: In mode 1 (derive), computation starts on enable with no data input. The result overwrites key words 0 to 3, with word 0 taken from result[31:0], and enable then reads back as 0. Key-word reads return 0 while enable is 1 and the mode is 1.
- R7: The completion flag is set when a computation ends. `irq` rises only if the completion-interrupt enable is set.
- R8: When the DMA-output bit is 1, the completion flag is not set.
- R9: A data-in write during the compute or output phase sets the write-error flag and is otherwise ignored, and the block in progress is unaffected.
- R10: A data-out read during the input or compute phase returns 0, sets the read-error flag and does not consume an output word.
- R11: Each flag is sticky until 1 is written to its clear bit. `irq` is raised by either error flag when the error-interrupt enable is set.
- R12: Writing enable to 0 returns the sequencer to its initial phase and drops any partially written input block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| irq | output | 1 | Combined interrupt |
| core_start | output | 1 | One-cycle start to the cipher core |
| core_data | output | 128 | Input block to the core |
| core_key | output | 256 | Key image to the core |
| core_mode | output | 2 | Mode code to the core |
| core_done | input | 1 | One-cycle completion from the core |
| core_result | input | 128 | Result block from the core |

## Verification
The main sequence runs four ways. Encrypt with a 128-bit key and gaps between writes shows the word order and that the upper key half is zeroed. Decrypt with a 256-bit key shows that key words 4 to 7 reach the core. A run with DMA output on separates the completion flag from the data path. Derive mode is the only pattern with no data input, and it shows the key write-back and the self-clearing enable. Out-of-order accesses are placed inside a running block to show that they set the error flags while the outputs stay correct. A second case drops enable halfway through an input block to show that the stale words are discarded.

// File: rtl/cipher_seq_pkg.sv
package cipher_seq_pkg;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 4;
    localparam int KEY_WORDS = 8;
    localparam int ADDR_W    = 4;
    localparam int BLK_W     = WORD_W * BLK_WORDS;
    localparam int KEY_W     = WORD_W * KEY_WORDS;
    localparam int CNT_W     = $clog2(BLK_WORDS);
    localparam int KIDX_W    = $clog2(KEY_WORDS);
    localparam int KEY_BASE  = 8;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(3);

    localparam int CLR_CCF_BIT = 7;
    localparam int CLR_RD_BIT  = 8;
    localparam int CLR_WR_BIT  = 9;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_INPUT   = 2'd1,
        PH_COMPUTE = 2'd2,
        PH_OUTPUT  = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        MODE_ENC    = 2'd0,
        MODE_DERIVE = 2'd1,
        MODE_DEC    = 2'd2,
        MODE_DERDEC = 2'd3
    } mode_t;

    typedef struct packed {
        logic  dma_out;
        logic  err_ie;
        logic  ccf_ie;
        logic  klen256;
        mode_t mode;
        logic  en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic is_key_addr(input logic [ADDR_W-1:0] a);
        return a >= ADDR_W'(KEY_BASE);
    endfunction

    function automatic logic [KEY_W-1:0] key_image(input logic [KEY_W-1:0] k,
                                                   input logic wide);
        logic [KEY_W-1:0] r;
        r = k;
        if (!wide) r[KEY_W-1:KEY_W/2] = '0;
        return r;
    endfunction
endpackage

// File: rtl/cipher_seq_regs.sv
module cipher_seq_regs
    import cipher_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              wb_en,
    input  logic [BLK_W-1:0]  wb_data,
    output ctrl_t             ctrl,
    output logic [KEY_W-1:0]  key_flat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wb_en) begin
            ctrl.en <= 1'b0;
        end else if (wr && addr == A_CTRL) begin
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    for (genvar i = 0; i < KEY_WORDS; i++) begin : g_key
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(KEY_BASE + i);
        logic [WORD_W-1:0] q;
        logic              wb_hit;

        if (i < BLK_WORDS) begin : g_wb
            assign wb_hit = wb_en;
        end else begin : g_nowb
            assign wb_hit = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wb_hit) begin
                q <= wb_data[WORD_W*(i % BLK_WORDS) +: WORD_W];
            end else if (wr && addr == MY_ADDR && !ctrl.en) begin
                q <= wdata;
            end
        end

        assign key_flat[WORD_W*i +: WORD_W] = q;

        // R3: key word is frozen while enabled
        a_r3_key_locked: assert property (@(posedge clk) disable iff (rst)
            (wr && addr == MY_ADDR && ctrl.en && !wb_en) |=> $stable(q));
    end

    // R6: derivation write-back drops enable
    a_r6_derive_clears_en: assert property (@(posedge clk) disable iff (rst)
        wb_en |=> !ctrl.en);
endmodule

// File: rtl/cipher_seq_fsm.sv
module cipher_seq_fsm
    import cipher_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  mode_t             mode,
    input  logic              din_we,
    input  logic              dout_re,
    input  logic [WORD_W-1:0] wdata,
    input  logic              core_done,
    input  logic [BLK_W-1:0]  core_result,
    output phase_t            phase,
    output logic              core_start,
    output logic [BLK_W-1:0]  blk_data,
    output logic [BLK_W-1:0]  res_data,
    output logic [WORD_W-1:0] dout_word,
    output logic              done_evt,
    output logic              wb_en,
    output logic              bad_wr,
    output logic              bad_rd
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_WORDS - 1);

    logic [CNT_W-1:0]  cnt;
    logic              start_q;
    logic [WORD_W-1:0] din_w [BLK_WORDS];
    logic [BLK_W-1:0]  res_q;
    logic [WORD_W-1:0] res_w [BLK_WORDS];

    for (genvar g = 0; g < BLK_WORDS; g++) begin : g_pack
        assign blk_data[WORD_W*g +: WORD_W] = din_w[g];
        assign res_w[g] = res_q[WORD_W*g +: WORD_W];
    end

    assign core_start = start_q;
    assign res_data   = res_q;
    assign bad_wr     = din_we && (phase == PH_COMPUTE || phase == PH_OUTPUT);
    assign bad_rd     = dout_re && (phase == PH_INPUT || phase == PH_COMPUTE);
    assign done_evt   = en && phase == PH_COMPUTE && core_done;
    assign wb_en      = done_evt && mode == MODE_DERIVE;
    assign dout_word  = (phase == PH_OUTPUT) ? res_w[LAST - cnt] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            start_q <= 1'b0;
            res_q   <= '0;
            for (int i = 0; i < BLK_WORDS; i++) din_w[i] <= '0;
        end else begin
            start_q <= 1'b0;
            if (!en) begin
                phase <= PH_IDLE;
                cnt   <= '0;
            end else begin
                unique case (phase)
                    PH_IDLE: begin
                        cnt <= '0;
                        if (mode == MODE_DERIVE) begin
                            phase   <= PH_COMPUTE;
                            start_q <= 1'b1;
                        end else begin
                            phase <= PH_INPUT;
                        end
                    end
                    PH_INPUT: begin
                        if (din_we) begin
                            din_w[LAST - cnt] <= wdata;
                            if (cnt == LAST) begin
                                phase   <= PH_COMPUTE;
                                start_q <= 1'b1;
                                cnt     <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    PH_COMPUTE: begin
                        if (core_done) begin
                            if (mode == MODE_DERIVE) begin
                                phase <= PH_IDLE;
                            end else begin
                                phase <= PH_OUTPUT;
                                res_q <= core_result;
                                cnt   <= '0;
                            end
                        end
                    end
                    PH_OUTPUT: begin
                        if (dout_re) begin
                            if (cnt == LAST) begin
                                phase <= PH_INPUT;
                                cnt   <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // R4: start is a single-cycle pulse
    a_r4_start_pulse: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start);
    // R9: a misplaced write leaves the phase where it was
    a_r9_bad_wr_holds_phase: assert property (@(posedge clk) disable iff (rst)
        (bad_wr && en && !core_done) |=> phase == $past(phase));
    // R10: a misplaced read does not consume an output word
    a_r10_bad_rd_no_output: assert property (@(posedge clk) disable iff (rst)
        bad_rd |=> phase != PH_OUTPUT || $past(phase) == PH_COMPUTE);
    // R12: dropping enable returns to the initial phase
    a_r12_disable_idles: assert property (@(posedge clk) disable iff (rst)
        !en |=> phase == PH_IDLE);
endmodule

// File: rtl/cipher_seq_flags.sv
module cipher_seq_flags (
    input  logic clk,
    input  logic rst,
    input  logic done_evt,
    input  logic dma_out,
    input  logic bad_rd,
    input  logic bad_wr,
    input  logic clr_ccf,
    input  logic clr_rd,
    input  logic clr_wr,
    input  logic ccf_ie,
    input  logic err_ie,
    output logic ccf,
    output logic rderr,
    output logic wrerr,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ccf   <= 1'b0;
            rderr <= 1'b0;
            wrerr <= 1'b0;
        end else begin
            if (done_evt && !dma_out) ccf <= 1'b1;
            else if (clr_ccf)         ccf <= 1'b0;
            if (bad_rd)               rderr <= 1'b1;
            else if (clr_rd)          rderr <= 1'b0;
            if (bad_wr)               wrerr <= 1'b1;
            else if (clr_wr)          wrerr <= 1'b0;
        end
    end

    assign irq = (ccf && ccf_ie) || ((rderr || wrerr) && err_ie);

    // R7: completion sets the flag
    a_r7_ccf_on_done: assert property (@(posedge clk) disable iff (rst)
        (done_evt && !dma_out) |=> ccf);
    // R8: DMA output keeps a clear flag clear
    a_r8_dma_no_ccf: assert property (@(posedge clk) disable iff (rst)
        (done_evt && dma_out && !ccf) |=> !ccf);
    // R11: flags hold until cleared
    a_r11_ccf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ccf && !clr_ccf) |=> ccf);
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (rderr && !clr_rd) |=> rderr);
endmodule

// File: rtl/cipher_seq_top.sv
module cipher_seq_top
    import cipher_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq,
    output logic              core_start,
    output logic [BLK_W-1:0]  core_data,
    output logic [KEY_W-1:0]  core_key,
    output logic [1:0]        core_mode,
    input  logic              core_done,
    input  logic [BLK_W-1:0]  core_result
);
    ctrl_t             ctrl;
    logic [KEY_W-1:0]  key_flat;
    phase_t            phase;
    logic [BLK_W-1:0]  res_data;
    logic [WORD_W-1:0] dout_word;
    logic              done_evt, wb_en, bad_wr, bad_rd;
    logic              ccf, rderr, wrerr;
    logic              din_we, dout_re, ctrl_we;
    logic [KIDX_W-1:0] kidx;

    assign din_we  = bus_wr && bus_addr == A_DIN;
    assign dout_re = bus_rd && bus_addr == A_DOUT;
    assign ctrl_we = bus_wr && bus_addr == A_CTRL;
    assign kidx    = bus_addr[KIDX_W-1:0];

    cipher_seq_regs u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .wb_en(wb_en), .wb_data(res_data_wb), .ctrl(ctrl), .key_flat(key_flat)
    );

    logic [BLK_W-1:0] res_data_wb;
    assign res_data_wb = core_result;

    cipher_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .en(ctrl.en), .mode(ctrl.mode),
        .din_we(din_we), .dout_re(dout_re), .wdata(bus_wdata),
        .core_done(core_done), .core_result(core_result),
        .phase(phase), .core_start(core_start), .blk_data(core_data),
        .res_data(res_data), .dout_word(dout_word), .done_evt(done_evt),
        .wb_en(wb_en), .bad_wr(bad_wr), .bad_rd(bad_rd)
    );

    cipher_seq_flags u_flags (
        .clk(clk), .rst(rst), .done_evt(done_evt), .dma_out(ctrl.dma_out),
        .bad_rd(bad_rd), .bad_wr(bad_wr),
        .clr_ccf(ctrl_we && bus_wdata[CLR_CCF_BIT]),
        .clr_rd(ctrl_we && bus_wdata[CLR_RD_BIT]),
        .clr_wr(ctrl_we && bus_wdata[CLR_WR_BIT]),
        .ccf_ie(ctrl.ccf_ie), .err_ie(ctrl.err_ie),
        .ccf(ccf), .rderr(rderr), .wrerr(wrerr), .irq(irq)
    );

    assign core_key  = key_image(key_flat, ctrl.klen256);
    assign core_mode = ctrl.mode;

    always_comb begin
        bus_rdata = '0;
        if (is_key_addr(bus_addr)) begin
            if (!(ctrl.en && ctrl.mode == MODE_DERIVE))
                bus_rdata = key_flat[WORD_W*kidx +: WORD_W];
        end else begin
            unique case (bus_addr)
                A_CTRL:  bus_rdata = WORD_W'(ctrl);
                A_STAT:  bus_rdata = WORD_W'({phase == PH_COMPUTE, wrerr, rderr, ccf});
                A_DOUT:  bus_rdata = dout_word;
                default: bus_rdata = '0;
            endcase
        end
    end

    // R6: key words read as zero while derivation is armed
    a_r6_key_hidden: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && is_key_addr(bus_addr) && ctrl.en && ctrl.mode == MODE_DERIVE)
        |-> bus_rdata == '0);
endmodule

// File: tb/cipher_seq_top_tb_top.sv
`timescale 1ns/1ps
module cipher_seq_top_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   addr = '0;
    logic         wr = 1'b0, rd = 1'b0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         irq, core_start, core_done;
    logic [127:0] core_data, core_result;
    logic [255:0] core_key;
    logic [1:0]   core_mode;

    int checks = 0;
    int errors = 0;

    logic [127:0] cap_data;
    logic [255:0] cap_key;
    logic [1:0]   cap_mode;
    int           lat;
    logic [31:0]  k [8];

    always #4 clk = ~clk;

    cipher_seq_top dut_i (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rd(rd), .bus_rdata(rdata), .irq(irq), .core_start(core_start),
        .core_data(core_data), .core_key(core_key), .core_mode(core_mode),
        .core_done(core_done), .core_result(core_result)
    );

    function automatic logic [127:0] model(input logic [127:0] d,
                                           input logic [255:0] kk,
                                           input logic [1:0] m);
        return ~d ^ kk[127:0] ^ {126'b0, m};
    endfunction

    // stand-in cipher core with a fixed latency
    always @(posedge clk) begin
        core_done <= 1'b0;
        if (rst) begin
            lat <= 0;
            core_result <= '0;
        end else if (core_start) begin
            cap_data    <= core_data;
            cap_key     <= core_key;
            cap_mode    <= core_mode;
            core_result <= model(core_data, core_key, core_mode);
            lat         <= 6;
        end else if (lat > 1) begin
            lat <= lat - 1;
        end else if (lat == 1) begin
            core_done <= 1'b1;
            lat       <= 0;
        end
    end

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic br(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_block(input logic [127:0] blk, input int gap);
        for (int i = 3; i >= 0; i--) begin
            bw(4'd2, blk[32*i +: 32]);
            idle(gap);
        end
    endtask

    task automatic pull_check(input string req, input logic [127:0] exp);
        logic [31:0] d;
        for (int i = 3; i >= 0; i--) begin
            br(4'd3, d);
            chk(req, 256'(d), 256'(exp[32*i +: 32]));
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        br(4'd0, d); chk("R1 ctrl", 256'(d), 0);
        br(4'd1, d); chk("R1 stat", 256'(d), 0);
        chk("R1 irq/start", 256'({irq, core_start}), 0);
    endtask

    task automatic t_keys;
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            k[i] = 32'h1357_0000 + 32'(i * 32'h0101_0101);
            bw(4'(8 + i), k[i]);
        end
        for (int i = 0; i < 8; i++) begin
            br(4'(8 + i), d); chk("R2 key readback", 256'(d), 256'(k[i]));
        end
    endtask

    task automatic t_encrypt;
        logic [127:0] blk = 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff;
        logic [31:0] d;
        bw(4'd0, 32'h11);                    // en, mode 0, ccf irq enabled
        push_block(blk, 3);                  // R4 gaps between writes
        idle(14);
        chk("R4 data order", 256'(cap_data), 256'(blk));
        chk("R4 mode code", 256'(cap_mode), 0);
        chk("R2 upper half zero", cap_key, {128'b0, k[3], k[2], k[1], k[0]});
        br(4'd1, d); chk("R7 ccf set", 256'(d), 256'(1));
        chk("R7 irq", 256'(irq), 1);
        pull_check("R5 output words", model(blk, cap_key, 2'd0));
        bw(4'd0, 32'h11 | (32'd1 << 7));
        br(4'd1, d); chk("R11 ccf cleared", 256'(d), 0);
        chk("R11 irq low", 256'(irq), 0);
    endtask

    task automatic t_decrypt_errors;
        logic [127:0] blk = 128'hfeed_beef_0bad_f00d_1234_5678_9abc_def0;
        logic [31:0] d;
        bw(4'd0, 32'h0);
        bw(4'd0, 32'hD);                     // en, mode 2, 256-bit key
        push_block(blk, 0);
        idle(14);
        chk("R2 full key", cap_key, {k[7], k[6], k[5], k[4], k[3], k[2], k[1], k[0]});
        chk("R4 mode code dec", 256'(cap_mode), 2);
        chk("R7 no irq without enable", 256'(irq), 0);
        bw(4'd2, 32'hAAAA_5555);             // R9 misplaced write
        br(4'd1, d); chk("R9 wrerr set", 256'(d & 32'h4), 4);
        pull_check("R9 outputs intact", model(blk, cap_key, 2'd2));
        br(4'd3, d); chk("R10 early read zero", 256'(d), 0);
        br(4'd1, d); chk("R10 rderr set", 256'(d & 32'h2), 2);
        bw(4'd8, 32'hDEAD_0000);             // R3 locked key write
        br(4'd8, d); chk("R3 key unchanged", 256'(d), 256'(k[0]));
        bw(4'd0, 32'h2D);
        chk("R11 err irq", 256'(irq), 1);
        bw(4'd0, 32'h2D | (32'd3 << 8));
        br(4'd1, d); chk("R11 err cleared", 256'(d & 32'h6), 0);
        push_block(blk ^ 128'h1, 0);         // R10 read did not consume a word
        idle(14);
        pull_check("R10 next block", model(blk ^ 128'h1, cap_key, 2'd2));
    endtask

    task automatic t_disable;
        logic [127:0] blk = 128'h0f0f_0f0f_a5a5_a5a5_3c3c_3c3c_9696_9696;
        bw(4'd0, 32'h0);
        bw(4'd0, 32'h1);
        bw(4'd2, 32'h1111_1111);
        bw(4'd2, 32'h2222_2222);
        bw(4'd0, 32'h0);
        bw(4'd0, 32'h1);
        push_block(blk, 1);
        idle(14);
        chk("R12 stale words dropped", 256'(cap_data), 256'(blk));
        pull_check("R12 output", model(blk, cap_key, 2'd0));
    endtask

    task automatic t_dma;
        logic [127:0] blk = 128'h7777_6666_5555_4444_3333_2222_1111_0000;
        logic [31:0] d;
        bw(4'd0, 32'h51 | (32'd1 << 7));     // en, dma, ccf irq, clear ccf
        push_block(blk, 0);
        idle(14);
        br(4'd1, d); chk("R8 no ccf with dma", 256'(d & 32'h1), 0);
        chk("R8 no irq with dma", 256'(irq), 0);
        pull_check("R8 output", model(blk, cap_key, 2'd0));
    endtask

    task automatic t_derive;
        logic [31:0]  d;
        logic [127:0] exp;
        bw(4'd0, 32'h0);
        bw(4'd0, 32'h3);                     // en, mode 1
        br(4'd8, d); chk("R6 key hidden", 256'(d), 0);
        idle(14);
        chk("R6 mode code", 256'(cap_mode), 1);
        exp = model(cap_data, cap_key, 2'd1);
        br(4'd0, d); chk("R6 enable cleared", 256'(d), 256'(2));
        for (int i = 0; i < 4; i++) begin
            br(4'(8 + i), d); chk("R6 key written back", 256'(d), 256'(exp[32*i +: 32]));
        end
        br(4'd12, d); chk("R6 upper key kept", 256'(d), 256'(k[4]));
        br(4'd1, d); chk("R7 ccf after derive", 256'(d & 32'h1), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_keys();
        t_encrypt();
        t_decrypt_errors();
        t_disable();
        t_dma();
        t_derive();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule